// File: doc/BRIEF.md
# UART Interrupt Priority and Identification

This block sits beside the register file of a 16550-style serial controller and decides which interrupt the processor sees. Four kinds of condition can request service: a receive error or break (line status), enough received characters in the receive FIFO (or a character timeout), an empty transmit holding register, and a change on a modem control input. Each request is gated by its bit in the interrupt enable mask. The highest-ranked surviving request is encoded into the identification byte that software reads. A single interrupt line is asserted whenever any request survives and the OUT2 bit of the modem control register is set.

The line status, transmitter-empty, modem and timeout requests are sticky. A one-cycle event pulse from the rest of the controller raises each of them, and register-access strobes clear them: reading the line status register, reading the modem status register, reading the receive buffer, writing the transmit holding register, or reading the identification register while the transmitter-empty request is the one being reported. The received-data request is not stored. It is compared each cycle against the receive FIFO fill count and the trigger level chosen by the FIFO control register, so it drops as soon as the count falls below that level.

Top module: `uart_irq_ident`

## Requirements
- R1: Among enabled requests, line status outranks received data (including timeout), which outranks transmitter empty, which outranks modem status. Only the highest one is reported.
- R2: Identification bits 2-1 hold the reported source: 2'b11 line status, 2'b10 received data, 2'b01 transmitter empty, 2'b00 modem status. Bit 0 is 0 while a request is reported and 1 when none is, and then bits 3-1 are 0.
- R3: The trigger selector value 0 means 1 byte, 1 means 4, 2 means 8 and 3 means 14. The received-data request is active while the fill count is at or above the level and inactive once the count drops below it. With the FIFOs disabled the level is 1 byte.
- R4: A timeout event raises a request that ranks with received data. Whenever received data is the reported source, bit 3 of the identification byte is 1 if a timeout is pending and 0 otherwise. A receive-buffer read clears the timeout.
- R5: Bits 5-4 always read 0. Bits 7-6 read 2'b11 with the FIFOs enabled and 2'b00 with them disabled.
- R6: The interrupt output equals (OUT2 and some request reported). With OUT2 clear it stays 0.
- R7: Enable mask bit 0 gates received data and timeout, bit 1 gates transmitter empty, bit 2 gates line status, and bit 3 gates modem status. A masked request is never reported, but it stays stored and is reported as soon as its enable bit is set.
- R8: An identification read clears the transmitter-empty request only when that request is the one reported in that cycle. A transmit-holding write clears it unconditionally.
- R9: A line status read clears the line request and a modem status read clears the modem request. An event arriving in the same cycle as its clear strobe wins, so the request stays set.
- R10: After reset no request is stored, so the identification byte reads 8'h01 (FIFOs disabled) and the interrupt output is 0. An event pulse is reported from the clock edge that samples it and remains reported after the pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_en | input | 4 | Interrupt enable mask (bit 0 rx data/timeout, 1 tx empty, 2 line, 3 modem) |
| mcr_out2 | input | 1 | OUT2 bit of the modem control register; gates the interrupt line |
| fifo_en | input | 1 | FIFOs enabled |
| trig_sel | input | 2 | Receive trigger level selector from the FIFO control register |
| rx_count | input | COUNT_W | Receive FIFO fill count |
| line_evt | input | 1 | Pulse: receive error or break detected |
| thr_evt | input | 1 | Pulse: transmit holding register became empty |
| modem_evt | input | 1 | Pulse: a modem input changed |
| timeout_evt | input | 1 | Pulse: character timeout detected |
| rd_iir | input | 1 | Strobe: identification register read |
| rd_lsr | input | 1 | Strobe: line status register read |
| rd_msr | input | 1 | Strobe: modem status register read |
| rd_rbr | input | 1 | Strobe: receive buffer read |
| wr_thr | input | 1 | Strobe: transmit holding register write |
| iir | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request line |

## Verification
The hardest case to reach is the conditional clear on an identification read. The transmitter-empty request must be pending, and it must be reported only because every higher request is absent or masked. Then a second test must show that the same read, made while a higher source is reported, leaves it stored. The stimulus builds both stacks on purpose: first transmitter empty with modem status under it, then line status above transmitter empty. In the second stack, removing line status with a line status read exposes the transmitter-empty request that must have survived. A wide sweep over every enable mask, every stored-request pattern, both FIFO modes and both OUT2 values covers the priority rules, and a second sweep walks the fill count across every trigger level.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    // Source codes placed in identification bits 2-1
    typedef enum logic [1:0] {
        SRC_MODEM = 2'b00,
        SRC_THR   = 2'b01,
        SRC_RXD   = 2'b10,
        SRC_LINE  = 2'b11
    } irq_id_e;

    // Identification byte layout, msb first
    typedef struct packed {
        logic [1:0] fifo_state;
        logic [1:0] rsvd;
        logic       timeout;
        irq_id_e    id;
        logic       none;
    } iir_t;

    // Request vector in enable-mask bit order (bit 3 .. bit 0)
    typedef struct packed {
        logic modem;
        logic line;
        logic thr;
        logic rxd;
    } irq_vec_t;

    localparam int unsigned NUM_STICKY = 4;
    localparam int unsigned ST_LINE    = 0;
    localparam int unsigned ST_THR     = 1;
    localparam int unsigned ST_MODEM   = 2;
    localparam int unsigned ST_TMO     = 3;

    localparam int unsigned LVL_SEL0 = 1;
    localparam int unsigned LVL_SEL1 = 4;
    localparam int unsigned LVL_SEL2 = 8;
    localparam int unsigned LVL_SEL3 = 14;
    localparam int unsigned LVL_NOFIFO = 1;

    function automatic int unsigned trig_bytes(input logic [1:0] sel);
        case (sel)
            2'd0:    return LVL_SEL0;
            2'd1:    return LVL_SEL1;
            2'd2:    return LVL_SEL2;
            default: return LVL_SEL3;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic st;
        always_ff @(posedge clk) begin
            if (rst)
                st <= 1'b0;
            else if (set_i[i])
                st <= 1'b1;
            else if (clr_i[i])
                st <= 1'b0;
        end
        assign q_o[i] = st;
    end
endmodule

// File: rtl/uart_irq_rx_level.sv
module uart_irq_rx_level
    import uart_irq_pkg::*;
#(
    parameter int unsigned COUNT_W = 5
) (
    input  logic               fifo_en,
    input  logic [1:0]         trig_sel,
    input  logic [COUNT_W-1:0] rx_count,
    output logic               rx_ready
);
    localparam int unsigned LW = COUNT_W + 1;

    logic [LW-1:0] level;
    logic [LW-1:0] count_ext;

    always_comb begin
        if (fifo_en)
            level = LW'(trig_bytes(trig_sel));
        else
            level = LW'(LVL_NOFIFO);
        count_ext = {1'b0, rx_count};
        rx_ready  = (count_ext >= level);
    end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  irq_vec_t pend,
    input  logic     timeout,
    input  logic     fifo_en,
    output iir_t     iir_o,
    output logic     any_o
);
    always_comb begin
        iir_o            = '0;
        iir_o.fifo_state = {2{fifo_en}};
        iir_o.id         = SRC_MODEM;
        iir_o.none       = 1'b1;
        if (pend.line) begin
            iir_o.id   = SRC_LINE;
            iir_o.none = 1'b0;
        end else if (pend.rxd) begin
            iir_o.id      = SRC_RXD;
            iir_o.timeout = timeout;
            iir_o.none    = 1'b0;
        end else if (pend.thr) begin
            iir_o.id   = SRC_THR;
            iir_o.none = 1'b0;
        end else if (pend.modem) begin
            iir_o.id   = SRC_MODEM;
            iir_o.none = 1'b0;
        end
        any_o = |pend;
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int unsigned COUNT_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [3:0]         ier_en,
    input  logic               mcr_out2,
    input  logic               fifo_en,
    input  logic [1:0]         trig_sel,
    input  logic [COUNT_W-1:0] rx_count,
    input  logic               line_evt,
    input  logic               thr_evt,
    input  logic               modem_evt,
    input  logic               timeout_evt,
    input  logic               rd_iir,
    input  logic               rd_lsr,
    input  logic               rd_msr,
    input  logic               rd_rbr,
    input  logic               wr_thr,
    output logic [7:0]         iir,
    output logic               irq
);
    logic [NUM_STICKY-1:0] st_set;
    logic [NUM_STICKY-1:0] st_clr;
    logic [NUM_STICKY-1:0] st_q;
    logic                  rx_ready;
    irq_vec_t              mask;
    irq_vec_t              pend;
    iir_t                  iir_s;
    logic                  any_pend;
    logic                  thr_reported;

    assign mask = irq_vec_t'(ier_en);

    uart_irq_rx_level #(.COUNT_W(COUNT_W)) u_lvl (
        .fifo_en  (fifo_en),
        .trig_sel (trig_sel),
        .rx_count (rx_count),
        .rx_ready (rx_ready)
    );

    // Transmitter empty is cleared by an ID read only when it is the one shown
    assign thr_reported = !iir_s.none && (iir_s.id == SRC_THR);

    always_comb begin
        st_set           = '0;
        st_set[ST_LINE]  = line_evt;
        st_set[ST_THR]   = thr_evt;
        st_set[ST_MODEM] = modem_evt;
        st_set[ST_TMO]   = timeout_evt;
        st_clr           = '0;
        st_clr[ST_LINE]  = rd_lsr;
        st_clr[ST_THR]   = wr_thr || (rd_iir && thr_reported);
        st_clr[ST_MODEM] = rd_msr;
        st_clr[ST_TMO]   = rd_rbr;
    end

    uart_irq_sticky #(.N(NUM_STICKY)) u_st (
        .clk   (clk),
        .rst   (rst),
        .set_i (st_set),
        .clr_i (st_clr),
        .q_o   (st_q)
    );

    always_comb begin
        pend.line  = mask.line  && st_q[ST_LINE];
        pend.rxd   = mask.rxd   && (rx_ready || st_q[ST_TMO]);
        pend.thr   = mask.thr   && st_q[ST_THR];
        pend.modem = mask.modem && st_q[ST_MODEM];
    end

    uart_irq_prio u_prio (
        .pend    (pend),
        .timeout (st_q[ST_TMO]),
        .fifo_en (fifo_en),
        .iir_o   (iir_s),
        .any_o   (any_pend)
    );

    assign iir = iir_s;
    assign irq = mcr_out2 && any_pend;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
    parameter int unsigned COUNT_W = 5
) (
    input logic               clk,
    input logic               rst,
    input logic [3:0]         ier_en,
    input logic               mcr_out2,
    input logic               fifo_en,
    input logic [COUNT_W-1:0] rx_count,
    input logic               line_evt,
    input logic               thr_evt,
    input logic               modem_evt,
    input logic               rd_iir,
    input logic               rd_msr,
    input logic               wr_thr,
    input logic [7:0]         iir,
    input logic               irq
);
    // R6: OUT2 low keeps the line quiet
    p_irq_gated_r6: assert property (@(posedge clk) disable iff (rst)
        !mcr_out2 |-> !irq);

    // R2 / R6: line follows the pending flag when OUT2 is set
    p_irq_matches_id_r2: assert property (@(posedge clk) disable iff (rst)
        mcr_out2 |-> (irq == !iir[0]));

    // R5: reserved bits and FIFO state field
    p_reserved_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (iir[5:4] == 2'b00) && (iir[7:6] == {2{fifo_en}}));

    // R1: a line event with its enable set is reported next cycle
    p_line_first_r1: assert property (@(posedge clk) disable iff (rst)
        (line_evt && ier_en[2]) |=> (!ier_en[2] || iir[3:0] == 4'b0110));

    // R3: an empty FIFO never yields a plain received-data report
    p_rx_empty_r3: assert property (@(posedge clk) disable iff (rst)
        (rx_count == '0) |-> (iir[3:0] != 4'b0100));

    // R8: a holding-register write removes the transmitter-empty report
    p_thr_write_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_thr && !thr_evt) |=> (iir[2:1] != 2'b01));

    // R8: an ID read while transmitter-empty is shown removes it
    p_thr_idread_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_iir && iir[3:0] == 4'b0010 && !thr_evt) |=> (iir[3:0] != 4'b0010));

    // R9: a modem status read removes the modem report
    p_modem_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_msr && !modem_evt) |=> (iir[3:0] != 4'b0000));
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.COUNT_W(COUNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ier_en    (ier_en),
    .mcr_out2  (mcr_out2),
    .fifo_en   (fifo_en),
    .rx_count  (rx_count),
    .line_evt  (line_evt),
    .thr_evt   (thr_evt),
    .modem_evt (modem_evt),
    .rd_iir    (rd_iir),
    .rd_msr    (rd_msr),
    .wr_thr    (wr_thr),
    .iir       (iir),
    .irq       (irq)
);

// File: tb/sim_uart_irq_ident.sv
`timescale 1ns/1ps
module sim_uart_irq_ident;
    localparam int unsigned CW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    ier_en = '0;
    logic          mcr_out2 = 1'b0;
    logic          fifo_en = 1'b0;
    logic [1:0]    trig_sel = '0;
    logic [CW-1:0] rx_count = '0;
    logic          line_evt = 0, thr_evt = 0, modem_evt = 0, timeout_evt = 0;
    logic          rd_iir = 0, rd_lsr = 0, rd_msr = 0, rd_rbr = 0, wr_thr = 0;
    logic [7:0]    iir;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    uart_irq_ident #(.COUNT_W(CW)) u0 (.*);

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic chk1(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    // Expected identification byte, from the requirement text
    function automatic logic [7:0] model(input logic [3:0] en, input logic ls, input logic rxa,
                                         input logic to, input logic thr, input logic ms,
                                         input logic fen);
        logic [3:0] low;
        if (ls && en[2])               low = 4'b0110;
        else if ((rxa || to) && en[0]) low = {to, 3'b100};
        else if (thr && en[1])         low = 4'b0010;
        else if (ms && en[3])          low = 4'b0000;
        else                           low = 4'b0001;
        return {{2{fen}}, 2'b00, low};
    endfunction

    function automatic int lvl_of(input logic [1:0] t);
        if (t == 2'd0) return 1;
        if (t == 2'd3) return 14;
        return 4 * int'(t);
    endfunction

    task automatic clear_all();
        rd_lsr = 1; rd_msr = 1; rd_rbr = 1; wr_thr = 1;
        tick();
        rd_lsr = 0; rd_msr = 0; rd_rbr = 0; wr_thr = 0;
    endtask

    task automatic pulse(input logic ls, input logic thr, input logic ms, input logic to);
        line_evt = ls; thr_evt = thr; modem_evt = ms; timeout_evt = to;
        tick();
        line_evt = 0; thr_evt = 0; modem_evt = 0; timeout_evt = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        tick();
        // R10: reset state
        chk8("R10 reset iir", iir, 8'h01);
        chk1("R10 reset irq", irq, 1'b0);

        // R1 R2 R5 R6 R7 R4: sweep of masks, stored requests, modes
        for (int e = 0; e < 16; e++) begin
            for (int s = 0; s < 16; s++) begin
                for (int r = 0; r < 2; r++) begin
                    for (int f = 0; f < 2; f++) begin
                        for (int o = 0; o < 2; o++) begin
                            logic [7:0] ex;
                            ier_en = 4'(e); fifo_en = f[0]; mcr_out2 = o[0];
                            trig_sel = 2'd0; rx_count = CW'(r);
                            clear_all();
                            pulse(s[0], s[1], s[2], s[3]);
                            ex = model(4'(e), s[0], r[0], s[3], s[1], s[2], f[0]);
                            chk8("R1/R2/R5/R7 sweep iir", iir, ex);
                            chk1("R6 sweep irq", irq, o[0] & ~ex[0]);
                        end
                    end
                end
            end
        end

        // R3: trigger levels across every fill count
        ier_en = 4'b0001; mcr_out2 = 1;
        clear_all();
        for (int f = 0; f < 2; f++) begin
            for (int t = 0; t < 4; t++) begin
                for (int c = 0; c <= 16; c++) begin
                    int lv;
                    fifo_en = f[0]; trig_sel = 2'(t); rx_count = CW'(c);
                    lv = f ? lvl_of(2'(t)) : 1;
                    tick();
                    chk8("R3 trigger level", iir, model(4'b0001, 0, c >= lv, 0, 0, 0, f[0]));
                end
                // R3: count falling below the level drops the request
                rx_count = CW'(lvl_of(2'(t)) - 1);
                tick();
                chk1("R3 drop below level", iir[0], (f == 0) ? (lvl_of(2'(t)) - 1 == 0) : 1'b1);
            end
        end
        fifo_en = 0; rx_count = '0; trig_sel = 0;

        // R8: ID read clears transmitter-empty only when it is reported
        ier_en = 4'b1010; clear_all();
        pulse(0, 1, 1, 0);
        chk8("R8 thr reported", iir, 8'h02);
        rd_iir = 1; tick(); rd_iir = 0;
        chk8("R8 id read exposes modem", iir, 8'h00);
        ier_en = 4'b0110; clear_all();
        pulse(1, 1, 0, 0);
        chk8("R8 line above thr", iir, 8'h06);
        rd_iir = 1; tick(); rd_iir = 0;
        chk8("R8 id read keeps line", iir, 8'h06);
        rd_lsr = 1; tick(); rd_lsr = 0;
        chk8("R8 thr survived id read", iir, 8'h02);
        wr_thr = 1; tick(); wr_thr = 0;
        chk8("R8 write clears thr", iir, 8'h01);
        chk1("R8 irq idle", irq, 1'b0);

        // R9: clear strobes and same-cycle event priority
        ier_en = 4'b1100; clear_all();
        line_evt = 1; rd_lsr = 1; tick(); line_evt = 0; rd_lsr = 0;
        chk8("R9 set wins over lsr read", iir, 8'h06);
        rd_lsr = 1; tick(); rd_lsr = 0;
        chk8("R9 lsr read clears", iir, 8'h01);
        pulse(0, 0, 1, 0);
        chk8("R9 modem reported", iir, 8'h00);
        rd_msr = 1; tick(); rd_msr = 0;
        chk8("R9 msr read clears", iir, 8'h01);

        // R4: timeout reporting and clearing
        ier_en = 4'b0101; clear_all();
        pulse(1, 0, 0, 1);
        chk8("R4 line above timeout", iir, 8'h06);
        rd_lsr = 1; tick(); rd_lsr = 0;
        chk8("R4 timeout reported", iir, 8'h0C);
        rd_rbr = 1; tick(); rd_rbr = 0;
        chk8("R4 rbr read clears timeout", iir, 8'h01);

        // R7 R10: masked request stays stored and persists
        ier_en = 4'b0000; clear_all();
        pulse(1, 0, 0, 0);
        chk8("R7 masked not reported", iir, 8'h01);
        chk1("R7 masked irq", irq, 1'b0);
        ier_en = 4'b0100;
        repeat (3) tick();
        chk8("R10 stored request persists", iir, 8'h06);
        chk1("R6 irq with out2", irq, 1'b1);
        mcr_out2 = 0; tick();
        chk1("R6 out2 clear gates irq", irq, 1'b0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule